// File: doc/BRIEF.md
# Four-Stage Watchdog with Tick Timer

This block is a memory-mapped watchdog. It has its own periodic tick timer, and both are advanced by a 1 MHz enable strobe supplied from outside. The timer divides the strobe down to an interval that software chooses. Each interval ends with a timer expiry, and each expiry steps an 8-bit watchdog countdown down by one. When the countdown runs out, it reloads and a 2-bit lapse counter advances. On the fourth lapse the block requests a system reset, provided that this is enabled. It then stops and clears its counters.

Software drives the block over a simple register bus. Writes are single-cycle strobes on one port. Reads come combinationally from a separate address port. Software sets the timer and the watchdog period, kicks the watchdog by writing the start command again, and reads the live countdown and lapse count. A stop command only takes effect if a key was written to the unlock register by the write just before it. An optional level interrupt warns software after the first lapse.

Top module: `staged_watchdog`

## Requirements
- R1: After reset every register reads zero, `irq` and `sys_rst_req` are low, and the watchdog is stopped.
- R2: The timer control word at byte offset 0x10 is laid out as follows. Bit 31 is enable and bit 30 is auto-reload. Bits [29:0] are the reload value, where 0 acts as 1. Writing the word loads the timer. An enabled timer expires once every reload strobes of `tick_1us`. Without auto-reload, the timer clears its own enable bit after one expiry. A disabled timer ignores strobes.
- R3: The config word at offset 0x0 is laid out as follows. Bits [3:0] hold a timer-select tag, which is stored and read back only. Bits [11:4] hold the period, where 0 acts as 1. Bit 12 enables the interrupt and bit 15 enables the reset request. All other bits read as zero.
- R4: Writing the command word at 0x8 with bit 0 set starts or kicks the watchdog. It becomes running, the countdown loads the period, the lapse count clears and the pending interrupt clears.
- R5: While running, each timer expiry decrements the countdown. An expiry that arrives with the countdown at 1 is a lapse: the countdown reloads the period and the lapse count rises by one.
- R6: The status word at 0x4 is laid out as follows. Bit 0 shows running, bits [11:4] the countdown and bits [13:12] the lapse count. A stopped watchdog shows zero in all three fields.
- R7: The fourth lapse occurs exactly 4×period expiries after a kick. It stops the watchdog and clears its fields. If bit 15 is set, `sys_rst_req` rises in the following cycle and stays high for exactly RST_PULSE clock cycles. If bit 15 is clear, `sys_rst_req` stays low.
- R8: `irq` is a level. It is high from the first lapse until a kick, a stop or the fourth lapse, and only while bit 12 is set.
- R9: Writing a value whose low 16 bits are 0xC45A to offset 0xC arms the unlock. A command write with bit 1 set while the unlock is armed stops the watchdog and clears its fields. When both command bits are set under an armed unlock, the stop takes precedence.
- R10: The unlock can be used once. Any other write disarms it, including a wrong key, a write to any other register and the stop command itself. A stop without an armed unlock is ignored.
- R11: Reads of the command offset, the unlock offset and unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1us | input | 1 | One-cycle strobe at 1 MHz |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Read byte address |
| rd_data | output | 32 | Read data, combinational |
| irq | output | 1 | Level interrupt after the first lapse |
| sys_rst_req | output | 1 | Reset request pulse |

## Verification
A countdown or lapse counter that is off by one appears at once in the status word, which the bench reads after every single strobe. It also moves the rise of `sys_rst_req` by at least one expiry relative to the 4×period arithmetic. A lost unlock state shows up within one write: the next stop either takes effect when it should not, or is ignored when it should take effect, and the running bit reports which. A wrong pulse counter shows up as a reset request whose measured length differs from RST_PULSE.

// File: rtl/staged_watchdog.sv
module staged_watchdog #(
  parameter int          RELOAD_W   = 30,
  parameter int          RST_PULSE  = 16,
  parameter logic [15:0] UNLOCK_KEY = 16'hC45A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_1us,
  input  logic        wr_en,
  input  logic [4:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [4:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        irq,
  output logic        sys_rst_req
);

  localparam int PW_W = $clog2(RST_PULSE + 1);
  localparam logic [4:0] A_CFG = 5'h00, A_STS = 5'h04, A_CMD = 5'h08,
                         A_KEY = 5'h0C, A_TMR = 5'h10;
  localparam logic [RELOAD_W-1:0] ONE = RELOAD_W'(1);

  logic                tmr_on, tmr_auto;
  logic [RELOAD_W-1:0] tmr_reload, tmr_cnt;
  logic [3:0]          cfg_sel;
  logic [7:0]          cfg_period;
  logic                cfg_irq_en, cfg_rst_en;
  logic                running, armed, irq_flag;
  logic [7:0]          wd_cnt;
  logic [1:0]          wd_exp;
  logic [PW_W-1:0]     pulse_cnt;

  wire wr_cfg = wr_en && wr_addr == A_CFG;
  wire wr_cmd = wr_en && wr_addr == A_CMD;
  wire wr_key = wr_en && wr_addr == A_KEY;
  wire wr_tmr = wr_en && wr_addr == A_TMR;

  wire [RELOAD_W-1:0] wr_reload  = wr_data[RELOAD_W-1:0];
  wire [RELOAD_W-1:0] reload_eff = (tmr_reload == '0) ? ONE : tmr_reload;
  wire [7:0]          period_eff = (cfg_period == 8'd0) ? 8'd1 : cfg_period;

  wire tmr_fire = tmr_on && tick_1us && tmr_cnt <= ONE;
  wire do_stop  = wr_cmd && wr_data[1] && armed;
  wire do_kick  = wr_cmd && wr_data[0] && !do_stop;
  wire wd_step  = running && tmr_fire;
  wire wd_lapse = wd_step && wd_cnt <= 8'd1;
  wire fatal    = wd_lapse && wd_exp == 2'd3 && !do_stop && !do_kick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_on     <= 1'b0;
      tmr_auto   <= 1'b0;
      tmr_reload <= '0;
      tmr_cnt    <= '0;
    end else if (wr_tmr) begin
      tmr_on     <= wr_data[31];
      tmr_auto   <= wr_data[30];
      tmr_reload <= wr_reload;
      tmr_cnt    <= (wr_reload == '0) ? ONE : wr_reload;
    end else if (tmr_on && tick_1us) begin
      if (tmr_cnt <= ONE) begin
        tmr_cnt <= reload_eff;
        if (!tmr_auto) tmr_on <= 1'b0;
      end else begin
        tmr_cnt <= tmr_cnt - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_sel    <= '0;
      cfg_period <= '0;
      cfg_irq_en <= 1'b0;
      cfg_rst_en <= 1'b0;
    end else if (wr_cfg) begin
      cfg_sel    <= wr_data[3:0];
      cfg_period <= wr_data[11:4];
      cfg_irq_en <= wr_data[12];
      cfg_rst_en <= wr_data[15];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     armed <= 1'b0;
    else if (wr_en) armed <= wr_key && wr_data[15:0] == UNLOCK_KEY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      wd_cnt   <= '0;
      wd_exp   <= '0;
      irq_flag <= 1'b0;
    end else if (do_stop || fatal) begin
      running  <= 1'b0;
      wd_cnt   <= '0;
      wd_exp   <= '0;
      irq_flag <= 1'b0;
    end else if (do_kick) begin
      running  <= 1'b1;
      wd_cnt   <= period_eff;
      wd_exp   <= '0;
      irq_flag <= 1'b0;
    end else if (wd_lapse) begin
      wd_cnt   <= period_eff;
      wd_exp   <= wd_exp + 2'd1;
      irq_flag <= 1'b1;
    end else if (wd_step) begin
      wd_cnt   <= wd_cnt - 8'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   pulse_cnt <= '0;
    else if (fatal && cfg_rst_en) pulse_cnt <= PW_W'(RST_PULSE);
    else if (pulse_cnt != '0)     pulse_cnt <= pulse_cnt - PW_W'(1);
  end

  assign sys_rst_req = pulse_cnt != '0;
  assign irq         = irq_flag && cfg_irq_en;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CFG: rd_data = {16'd0, cfg_rst_en, 2'b00, cfg_irq_en, cfg_period, cfg_sel};
      A_STS: rd_data = {18'd0, wd_exp, wd_cnt, 3'b000, running};
      A_TMR: rd_data = {tmr_on, tmr_auto, {(30 - RELOAD_W){1'b0}}, tmr_reload};
      default: rd_data = '0;
    endcase
  end

endmodule

module watchdog_props #(
  parameter int RST_PULSE = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [4:0]  wr_addr,
  input logic [31:0] wr_data,
  input logic        irq,
  input logic        sys_rst_req,
  input logic        running,
  input logic        armed,
  input logic        cfg_rst_en,
  input logic [7:0]  wd_cnt,
  input logic [1:0]  wd_exp
);

  logic [15:0] hi_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           hi_len <= '0;
    else if (sys_rst_req) hi_len <= hi_len + 16'd1;
    else                  hi_len <= '0;
  end

  wire cmd_wr = wr_en && wr_addr == 5'h08;

  p_pulse_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hi_len <= 16'(RST_PULSE));

  p_rst_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_req) |-> $past(wd_exp) == 2'd3 && $past(cfg_rst_en) && !running);

  p_unkeyed_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && wr_data[1] && !wr_data[0] && !armed && running |=> running);

  p_kick_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && wr_data[0] && !(wr_data[1] && armed) |=> running && wd_exp == 2'd0 && wd_cnt != 8'd0);

  p_irq_running_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> running);

  p_idle_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> wd_cnt == 8'd0 && wd_exp == 2'd0);

endmodule

bind staged_watchdog watchdog_props #(.RST_PULSE(RST_PULSE)) u_props (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .irq(irq), .sys_rst_req(sys_rst_req), .running(running), .armed(armed),
  .cfg_rst_en(cfg_rst_en), .wd_cnt(wd_cnt), .wd_exp(wd_exp)
);

// File: tb/sim_staged_watchdog.sv
module sim_staged_watchdog;
  localparam int PULSE = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1us = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq, sys_rst_req;

  int n_chk = 0;
  int n_bad = 0;

  staged_watchdog #(.RST_PULSE(PULSE)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq), .sys_rst_req(sys_rst_req)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_1us = 1'b1;
      @(negedge clk); tick_1us = 1'b0;
    end
  endtask

  function automatic logic [31:0] sts(input int r, input int c, input int e);
    return 32'((e << 12) | (c << 4) | r);
  endfunction

  task automatic chk_sts(input string req, input int r, input int c, input int e);
    logic [31:0] d;
    rd(5'h04, d);
    check(req, d, sts(r, c, e));
  endtask

  task automatic pulse_len(input string req);
    int n = 0;
    while (sys_rst_req && n < 100) begin
      n++;
      @(negedge clk);
    end
    check(req, 32'(n), 32'(PULSE));
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int plist[4] = '{1, 2, 3, 5};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a <= 16; a += 4) begin
      rd(5'(a), d);
      check("R1 reg", d, 32'd0);
    end
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 rst", {31'd0, sys_rst_req}, 32'd0);

    // R3 config layout
    wr(5'h00, 32'h0000_9FF5);
    rd(5'h00, d); check("R3 cfg", d, 32'h0000_9FF5);
    wr(5'h00, 32'hFFFF_FFFF);
    rd(5'h00, d); check("R3 mask", d, 32'h0000_9FFF);
    // R2 timer readback
    wr(5'h10, 32'hC000_0001);
    rd(5'h10, d); check("R2 tmr", d, 32'hC000_0001);
    // R11 zero reads
    rd(5'h08, d); check("R11 cmd", d, 32'd0);
    rd(5'h0C, d); check("R11 key", d, 32'd0);
    rd(5'h14, d); check("R11 unmapped", d, 32'd0);
    rd(5'h1C, d); check("R11 unmapped", d, 32'd0);

    // R5 R6 R7 sweep over periods
    foreach (plist[i]) begin
      int p = plist[i];
      wr(5'h00, 32'((p << 4) | (1 << 15)));
      wr(5'h08, 32'd1);
      for (int k = 0; k < 4 * p; k++) begin
        chk_sts("R5 R6 status", 1, p - (k % p), k / p);
        check("R7 early", {31'd0, sys_rst_req}, 32'd0);
        tick(1);
      end
      check("R7 rise", {31'd0, sys_rst_req}, 32'd1);
      chk_sts("R7 cleared", 0, 0, 0);
      pulse_len("R7 length");
    end

    // R7 with reset disabled
    wr(5'h00, 32'h0000_0010);
    wr(5'h08, 32'd1);
    tick(4);
    check("R7 no req", {31'd0, sys_rst_req}, 32'd0);
    chk_sts("R7 stopped", 0, 0, 0);
    @(negedge clk);
    check("R7 no req later", {31'd0, sys_rst_req}, 32'd0);

    // R2 reload 3, period 2
    wr(5'h10, 32'hC000_0003);
    wr(5'h00, 32'h0000_0020);
    wr(5'h08, 32'd1);
    tick(2); chk_sts("R2 reload wait", 1, 2, 0);
    tick(1); chk_sts("R2 reload fire", 1, 1, 0);
    tick(3); chk_sts("R2 reload lapse", 1, 2, 1);
    // R2 one-shot
    wr(5'h10, 32'h8000_0002);
    wr(5'h08, 32'd1);
    tick(2); chk_sts("R2 one-shot", 1, 1, 0);
    rd(5'h10, d); check("R2 self-clear", d, 32'h0000_0002);
    tick(6); chk_sts("R2 halted", 1, 1, 0);
    // R2 disabled timer
    wr(5'h10, 32'h4000_0001);
    tick(5); chk_sts("R2 off", 1, 1, 0);

    // R4 kicks prevent reset
    wr(5'h10, 32'hC000_0001);
    wr(5'h00, 32'h0000_8030);
    wr(5'h08, 32'd1);
    tick(11);
    chk_sts("R4 before kick", 1, 1, 3);
    wr(5'h08, 32'd1);
    chk_sts("R4 after kick", 1, 3, 0);
    tick(11);
    check("R4 no req", {31'd0, sys_rst_req}, 32'd0);
    tick(1);
    check("R4 req", {31'd0, sys_rst_req}, 32'd1);
    pulse_len("R7 length after kick");

    // R8 interrupt
    wr(5'h00, 32'h0000_1020);
    wr(5'h08, 32'd1);
    tick(1); check("R8 quiet", {31'd0, irq}, 32'd0);
    tick(1); check("R8 raised", {31'd0, irq}, 32'd1);
    tick(3); check("R8 held", {31'd0, irq}, 32'd1);
    wr(5'h08, 32'd1);
    check("R8 kick clears", {31'd0, irq}, 32'd0);
    wr(5'h00, 32'h0000_0020);
    tick(2); check("R8 masked", {31'd0, irq}, 32'd0);

    // R9 R10 unlock
    wr(5'h08, 32'd1);
    wr(5'h08, 32'd2);
    chk_sts("R10 no key", 1, 2, 0);
    wr(5'h0C, 32'h0000_C45A); wr(5'h00, 32'h0000_0020); wr(5'h08, 32'd2);
    chk_sts("R10 other write", 1, 2, 0);
    wr(5'h0C, 32'h0000_C45B); wr(5'h08, 32'd2);
    chk_sts("R10 wrong key", 1, 2, 0);
    wr(5'h0C, 32'h0000_C45A); tick(1); wr(5'h08, 32'd2);
    chk_sts("R9 keyed stop", 0, 0, 0);
    wr(5'h08, 32'd1);
    wr(5'h0C, 32'h0000_C45A); wr(5'h08, 32'd3);
    chk_sts("R9 stop wins", 0, 0, 0);
    wr(5'h08, 32'd1);
    wr(5'h0C, 32'h0000_C45A); wr(5'h0C, 32'h0000_C45A); wr(5'h08, 32'd2);
    chk_sts("R9 rearmed", 0, 0, 0);
    wr(5'h08, 32'd2);
    wr(5'h08, 32'd1);
    wr(5'h08, 32'd2);
    chk_sts("R10 single use", 1, 2, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule